// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a small Ethernet DMA engine. Completed frames arrive as a byte stream with start and end markers and a set of address-match class flags. The block keeps a ring of two-word descriptors inside a local word memory. For each frame it picks the current descriptor, copies the frame bytes into the buffer that descriptor names, writes a status word holding the stored length and the class flags, and then hands the descriptor to software by setting its ownership bit.

The ring has no length register. The hardware steps through descriptors eight bytes apart and only returns to the ring base when the descriptor it has just filled carries a wrap flag. A descriptor whose ownership bit is still set is treated as busy. A frame that meets a busy descriptor is dropped, and a buffer-not-available flag is raised. Frames longer than the buffer are cut short, and an overrun flag is raised. Software reaches the same memory through a simple word port. It loads the ring base through a separate write strobe and clears the three sticky event flags by writing ones.

Top module: `rxr_ring_writer`

## Requirements
- R1: A frame that starts on a descriptor whose word 0 bit 0 is 0 is stored at the byte address formed from word 0 bits 31:2 with the low two bits zero. Frame byte k goes to byte offset k, and byte offset o sits in bits 8*(o mod 4)+7 down to 8*(o mod 4) of memory word o/4.
- R2: At the frame's last beat the descriptor's word 1 is written with the stored length in bits 10:0, zero in bits 22:11, and rx_class[8:0] in bits 31:23 (rx_class[8] lands in bit 31, rx_class[0] in bit 23).
- R3: At the frame's last beat word 0 bit 0 of the descriptor becomes 1, and all other bits of word 0 are left unchanged.
- R4: After a stored frame the current pointer moves to the descriptor 8 bytes further on. If word 0 bit 1 (wrap) of the used descriptor was 1, it returns to the ring base instead.
- R5: A frame whose start beat finds word 0 bit 0 already set is dropped. Nothing is written to memory, the buffer-not-available flag is set, and the current pointer stays on the same descriptor.
- R6: A ring base write loads the base with the written value and its low three bits cleared, and it moves the current pointer to that base.
- R7: A frame longer than BUF_BYTES stores only its first BUF_BYTES bytes and writes nothing past the buffer. It records BUF_BYTES as its length and sets the overrun flag.
- R8: The flags rx_done_flag (event bit 0), overrun_flag (bit 1) and no_buf_flag (bit 2) are sticky. Each is set one cycle after the beat that causes it: a stored frame's last beat for rx_done_flag, a truncated frame's last beat for overrun_flag, and a dropped frame's start beat for no_buf_flag. A flag clears when stat_clr_we is high with the matching stat_clr bit set, and setting wins over clearing.
- R9: After reset all three flags are 0, and the ring base and current pointer are 0.
- R10: Beats with rx_valid low, and beats without rx_sof while no frame is open, are ignored and leave memory and flags untouched.
- R11: sw_we writes sw_wdata to word sw_addr. sw_rdata returns word sw_addr in the same cycle when SW_READ_REG is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte beat valid |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_class | input | 9 | Address-match class flags, sampled on the last beat |
| ring_base_we | input | 1 | Ring base load strobe |
| ring_base_wdata | input | 32 | Ring base byte address |
| sw_we | input | 1 | Software word write |
| sw_addr | input | AW | Software word address |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data |
| stat_clr_we | input | 1 | Flag clear strobe |
| stat_clr | input | 3 | Write-one-to-clear mask {bna, overrun, done} |
| rx_done_flag | output | 1 | Frame stored |
| overrun_flag | output | 1 | Frame truncated |
| no_buf_flag | output | 1 | Frame dropped, descriptor busy |

## Verification
The assertions assume a well-formed stream: no rx_sof while a frame is open, and every frame closed by an rx_eof beat. They also assume that software does not rewrite a descriptor the hardware is filling, and that buffers do not overlap descriptor words. The stimulus sends every frame as one contiguous run of beats that begins with rx_sof and ends with rx_eof. It changes descriptors only while the stream is idle and places all buffers in a memory region apart from the descriptors. The stray beats used for the ignore check are sent only between frames.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
   localparam int OWN_BIT   = 0;
   localparam int WRAP_BIT  = 1;
   localparam int LEN_W     = 11;
   localparam int CLASS_W   = 9;
   localparam int N_EVT     = 3;
   localparam int MAX_BUF   = 1536;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RECV = 2'd1,
      ST_DROP = 2'd2
   } rxr_state_e;

   typedef struct packed {
      logic bna;
      logic ovr;
      logic done;
   } rxr_evt_t;
endpackage

// File: rtl/rxr_word_mem.sv
`timescale 1ns/1ps
module rxr_word_mem #(
   parameter int WORDS       = 512,
   parameter int SW_READ_REG = 0,
   localparam int AW         = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_addr,
   input  logic [31:0]   sw_wdata,
   output logic [31:0]   sw_rdata,
   input  logic          hw_byte_we,
   input  logic [AW-1:0] hw_byte_idx,
   input  logic [1:0]    hw_byte_lane,
   input  logic [7:0]    hw_byte_data,
   input  logic          hw_stat_we,
   input  logic [AW-1:0] hw_stat_idx,
   input  logic [31:0]   hw_stat_data,
   input  logic          hw_own_we,
   input  logic [AW-1:0] hw_own_idx,
   input  logic [AW-1:0] hw_rd_idx,
   output logic [31:0]   hw_rd_data
);
   logic [3:0][7:0] mem [WORDS];

   // later assignments win: hardware writes override a same-word software write
   always_ff @(posedge clk) begin
      if (sw_we)      mem[sw_addr] <= sw_wdata;
      if (hw_byte_we) mem[hw_byte_idx][hw_byte_lane] <= hw_byte_data;
      if (hw_stat_we) mem[hw_stat_idx] <= hw_stat_data;
      if (hw_own_we)  mem[hw_own_idx][0][0] <= 1'b1;
   end

   assign hw_rd_data = mem[hw_rd_idx];

   generate
      if (SW_READ_REG != 0) begin : g_rd_reg
         logic [31:0] rd_q;
         always_ff @(posedge clk) begin
            rd_q <= mem[sw_addr];
         end
         assign sw_rdata = rd_q;
      end else begin : g_rd_comb
         assign sw_rdata = mem[sw_addr];
      end
   endgenerate

   // checker state: remember the owner write and look at the word afterwards
   logic          own_chk_v;
   logic [AW-1:0] own_chk_idx;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_chk_v   <= 1'b0;
         own_chk_idx <= '0;
      end else begin
         own_chk_v   <= hw_own_we;
         own_chk_idx <= hw_own_idx;
      end
   end

   p_owner_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      own_chk_v |-> mem[own_chk_idx][0][0]);
endmodule

// File: rtl/rxr_frame_seq.sv
`timescale 1ns/1ps
module rxr_frame_seq
   import rxr_pkg::*;
#(
   parameter int AW        = 9,
   parameter int BUF_BYTES = 128,
   localparam int PA       = AW + 2,
   localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic [7:0]         rx_data,
   input  logic               rx_sof,
   input  logic               rx_eof,
   input  logic [CLASS_W-1:0] rx_class,
   input  logic               base_we,
   input  logic [31:0]        base_wdata,
   output logic [AW-1:0]      rd_idx,
   input  logic [31:0]        rd_word,
   output logic               byte_we,
   output logic [AW-1:0]      byte_idx,
   output logic [1:0]         byte_lane,
   output logic [7:0]         byte_data,
   output logic               stat_we,
   output logic [AW-1:0]      stat_idx,
   output logic [31:0]        stat_data,
   output logic               own_we,
   output logic [AW-1:0]      own_idx,
   output rxr_evt_t           evt
);
   rxr_state_e        state_q;
   logic [PA-1:0]     base_q, cur_q, desc_q, buf_q;
   logic              wrap_q, trunc_q;
   logic [CNT_W-1:0]  cnt_q;

   logic              start_ok, start_bna, in_recv, room, trunc_now, fin, fin_wrap;
   logic [PA-1:0]     byte_addr, fin_desc, rd_buf;
   logic [LEN_W-1:0]  len_now;

   logic unused_bits;
   assign unused_bits = ^{rd_word[31:PA], base_wdata[31:PA]};

   assign rd_idx    = cur_q[PA-1:2];
   assign rd_buf    = {rd_word[PA-1:2], 2'b00};
   assign start_ok  = (state_q == ST_IDLE) && rx_valid && rx_sof && !rd_word[OWN_BIT];
   assign start_bna = (state_q == ST_IDLE) && rx_valid && rx_sof &&  rd_word[OWN_BIT];
   assign in_recv   = (state_q == ST_RECV) && rx_valid;
   assign room      = cnt_q < CNT_W'(BUF_BYTES);
   assign trunc_now = in_recv && !room;
   assign fin       = (start_ok || in_recv) && rx_eof;
   assign fin_desc  = start_ok ? cur_q : desc_q;
   assign fin_wrap  = start_ok ? rd_word[WRAP_BIT] : wrap_q;

   always_comb begin
      byte_addr = start_ok ? rd_buf : (buf_q + PA'(cnt_q));
      if (start_ok) len_now = LEN_W'(1);
      else          len_now = LEN_W'(cnt_q) + (room ? LEN_W'(1) : LEN_W'(0));
   end

   assign byte_we   = start_ok || (in_recv && room);
   assign byte_idx  = byte_addr[PA-1:2];
   assign byte_lane = byte_addr[1:0];
   assign byte_data = rx_data;

   assign stat_we   = fin;
   assign stat_idx  = fin_desc[PA-1:2] + AW'(1);
   assign stat_data = {rx_class, {(32 - CLASS_W - LEN_W){1'b0}}, len_now};
   assign own_we    = fin;
   assign own_idx   = fin_desc[PA-1:2];

   assign evt.done  = fin;
   assign evt.ovr   = fin && (trunc_q || trunc_now);
   assign evt.bna   = start_bna;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         cur_q   <= '0;
         desc_q  <= '0;
         buf_q   <= '0;
         wrap_q  <= 1'b0;
         trunc_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  desc_q  <= cur_q;
                  buf_q   <= rd_buf;
                  wrap_q  <= rd_word[WRAP_BIT];
                  cnt_q   <= CNT_W'(1);
                  trunc_q <= 1'b0;
                  if (!rx_eof) state_q <= ST_RECV;
               end else if (start_bna && !rx_eof) begin
                  state_q <= ST_DROP;
               end
            end
            ST_RECV: begin
               if (rx_valid) begin
                  if (room) cnt_q <= cnt_q + CNT_W'(1);
                  else      trunc_q <= 1'b1;
                  if (rx_eof) state_q <= ST_IDLE;
               end
            end
            ST_DROP: begin
               if (rx_valid && rx_eof) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase

         if (base_we) begin
            base_q <= base_wdata[PA-1:0] & ~PA'(7);
            cur_q  <= base_wdata[PA-1:0] & ~PA'(7);
         end else if (fin) begin
            cur_q  <= fin_wrap ? base_q : (fin_desc + PA'(8));
         end
      end
   end

   p_cnt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BUF_BYTES));
   p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DROP) |-> (!byte_we && !stat_we && !own_we));
   p_bna_holds_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_bna && !base_we) |=> (cur_q == $past(cur_q)));
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !base_we && !fin_wrap) |=> (cur_q == $past(fin_desc) + PA'(8)));
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !base_we && fin_wrap) |=> (cur_q == $past(base_q)));
   p_base_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |=> ((cur_q == base_q) && (cur_q[2:0] == 3'b000)));
endmodule

// File: rtl/rxr_flags.sv
`timescale 1ns/1ps
module rxr_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_we,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic f_q;
         always_ff @(posedge clk) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= set[i] | (f_q & ~(clr_we & clr[i]));
         end
         assign flag[i] = f_q;

         p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> f_q);
         p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (f_q && !(clr_we && clr[i])) |=> f_q);
      end
   endgenerate
endmodule

// File: rtl/rxr_ring_writer.sv
`timescale 1ns/1ps
module rxr_ring_writer
   import rxr_pkg::*;
#(
   parameter int MEM_WORDS   = 512,
   parameter int BUF_BYTES   = 128,
   parameter int SW_READ_REG = 0,
   localparam int AW         = $clog2(MEM_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_sof,
   input  logic          rx_eof,
   input  logic [8:0]    rx_class,
   input  logic          ring_base_we,
   input  logic [31:0]   ring_base_wdata,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_addr,
   input  logic [31:0]   sw_wdata,
   output logic [31:0]   sw_rdata,
   input  logic          stat_clr_we,
   input  logic [2:0]    stat_clr,
   output logic          rx_done_flag,
   output logic          overrun_flag,
   output logic          no_buf_flag
);
   generate
      if (BUF_BYTES < 1 || BUF_BYTES > MAX_BUF) begin : g_bad_buf
         $error("BUF_BYTES must lie in 1..1536");
      end
      if (MEM_WORDS < 4 || (MEM_WORDS & (MEM_WORDS - 1)) != 0) begin : g_bad_mem
         $error("MEM_WORDS must be a power of two, at least 4");
      end
   endgenerate

   logic [AW-1:0]  rd_idx, byte_idx, stat_idx, own_idx;
   logic [31:0]    rd_word, stat_data;
   logic           byte_we, stat_we, own_we;
   logic [1:0]     byte_lane;
   logic [7:0]     byte_data;
   rxr_evt_t       evt;
   logic [N_EVT-1:0] flags;

   rxr_frame_seq #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_sof     (rx_sof),
      .rx_eof     (rx_eof),
      .rx_class   (rx_class),
      .base_we    (ring_base_we),
      .base_wdata (ring_base_wdata),
      .rd_idx     (rd_idx),
      .rd_word    (rd_word),
      .byte_we    (byte_we),
      .byte_idx   (byte_idx),
      .byte_lane  (byte_lane),
      .byte_data  (byte_data),
      .stat_we    (stat_we),
      .stat_idx   (stat_idx),
      .stat_data  (stat_data),
      .own_we     (own_we),
      .own_idx    (own_idx),
      .evt        (evt)
   );

   rxr_word_mem #(.WORDS(MEM_WORDS), .SW_READ_REG(SW_READ_REG)) u_mem (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_we        (sw_we),
      .sw_addr      (sw_addr),
      .sw_wdata     (sw_wdata),
      .sw_rdata     (sw_rdata),
      .hw_byte_we   (byte_we),
      .hw_byte_idx  (byte_idx),
      .hw_byte_lane (byte_lane),
      .hw_byte_data (byte_data),
      .hw_stat_we   (stat_we),
      .hw_stat_idx  (stat_idx),
      .hw_stat_data (stat_data),
      .hw_own_we    (own_we),
      .hw_own_idx   (own_idx),
      .hw_rd_idx    (rd_idx),
      .hw_rd_data   (rd_word)
   );

   rxr_flags #(.N(N_EVT)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (evt),
      .clr_we (stat_clr_we),
      .clr    (stat_clr),
      .flag   (flags)
   );

   assign rx_done_flag = flags[0];
   assign overrun_flag = flags[1];
   assign no_buf_flag  = flags[2];

   p_ovr_only_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt.ovr |-> evt.done);
   p_idle_beats_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> (!byte_we && !stat_we && !own_we && !evt.bna));
endmodule

// File: tb/tb_rxr_ring_writer.sv
`timescale 1ns/1ps
module tb_rxr_ring_writer;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 9;
   localparam int NV         = 4;

   // stimulus / expectation table for the four-descriptor ring
   localparam int          V_LEN [NV] = '{5, 1, 64, 17};
   localparam logic [8:0]  V_CLS [NV] = '{9'h100, 9'h0A5, 9'h001, 9'h1FF};
   localparam logic [7:0]  V_SEED[NV] = '{8'h11, 8'h22, 8'h33, 8'h44};
   localparam logic [31:0] V_W0  [NV] = '{32'h101, 32'h181, 32'h201, 32'h283};
   localparam logic [31:0] V_W1  [NV] = '{32'h80000005, 32'h52800001, 32'h00800040, 32'hFF800011};

   logic clk = 0, rst_n = 0;
   logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
   logic [7:0] rx_data = 0;
   logic [8:0] rx_class = 0;
   logic ring_base_we = 0;
   logic [31:0] ring_base_wdata = 0;
   logic sw_we = 0;
   logic [AW-1:0] sw_addr = 0;
   logic [31:0] sw_wdata = 0, sw_rdata;
   logic stat_clr_we = 0;
   logic [2:0] stat_clr = 0;
   logic rx_done_flag, overrun_flag, no_buf_flag;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxr_ring_writer dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_class(rx_class),
      .ring_base_we(ring_base_we), .ring_base_wdata(ring_base_wdata),
      .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
      .stat_clr_we(stat_clr_we), .stat_clr(stat_clr),
      .rx_done_flag(rx_done_flag), .overrun_flag(overrun_flag), .no_buf_flag(no_buf_flag)
   );

   function automatic logic [7:0] fb(input logic [7:0] seed, input int j);
      return seed + 8'(3 * j);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic sw_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      sw_addr = AW'(a); sw_wdata = d; sw_we = 1;
      @(negedge clk);
      sw_we = 0;
   endtask

   task automatic sw_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      sw_addr = AW'(a);
      #1 d = sw_rdata;
   endtask

   task automatic rd_byte(input int baddr, output logic [31:0] b);
      logic [31:0] w;
      sw_rd(baddr >> 2, w);
      b = (w >> (8 * (baddr % 4))) & 32'hFF;
   endtask

   task automatic send_frame(input int len, input logic [8:0] cls, input logic [7:0] seed);
      for (int j = 0; j < len; j++) begin
         @(negedge clk);
         rx_valid = 1; rx_data = fb(seed, j);
         rx_sof = (j == 0); rx_eof = (j == len - 1); rx_class = cls;
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0;
   endtask

   task automatic clr_flags(input logic [2:0] m);
      @(negedge clk);
      stat_clr_we = 1; stat_clr = m;
      @(negedge clk);
      stat_clr_we = 0; stat_clr = 0;
   endtask

   task automatic load_base(input logic [31:0] b);
      @(negedge clk);
      ring_base_we = 1; ring_base_wdata = b;
      @(negedge clk);
      ring_base_we = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R9 flags after reset", {29'd0, no_buf_flag, overrun_flag, rx_done_flag}, 32'd0);

      // ring of four descriptors at byte 0, buffers 128 bytes apart from 0x100
      for (int k = 0; k < NV; k++) begin
         sw_wr(2 * k, 32'h100 + 32'(128 * k) + ((k == NV - 1) ? 32'h2 : 32'h0));
         sw_wr(2 * k + 1, 32'h0);
      end
      sw_rd(6, v);
      chk("R11 software readback", v, 32'h282);

      // table walk: first frame also proves pointer starts at 0 (R9)
      for (int i = 0; i < NV; i++) begin
         send_frame(V_LEN[i], V_CLS[i], V_SEED[i]);
         chk("R8 done flag set", {31'd0, rx_done_flag}, 32'd1);
         sw_rd(2 * i + 1, v);
         chk("R2 status word", v, V_W1[i]);
         sw_rd(2 * i, v);
         chk("R3 owner set, address and wrap kept", v, V_W0[i]);
         rd_byte(256 + 128 * i, v);
         chk("R1 first byte", v, {24'd0, fb(V_SEED[i], 0)});
         rd_byte(256 + 128 * i + V_LEN[i] - 1, v);
         chk("R1 last byte", v, {24'd0, fb(V_SEED[i], V_LEN[i] - 1)});
         clr_flags(3'b001);
         chk("R8 done cleared by write-one", {31'd0, rx_done_flag}, 32'd0);
      end

      // ring full: pointer wrapped to descriptor 0, which is still owned
      send_frame(6, 9'h0, 8'h90);
      chk("R5 bna flag", {31'd0, no_buf_flag}, 32'd1);
      chk("R5 no done on drop", {31'd0, rx_done_flag}, 32'd0);
      sw_rd(1, v);
      chk("R5 status untouched", v, V_W1[0]);
      rd_byte(256, v);
      chk("R5 buffer untouched", v, {24'd0, fb(V_SEED[0], 0)});
      clr_flags(3'b100);

      // release descriptor 0; the next frame must land there (R4 wrap, R5 pointer kept)
      sw_wr(0, 32'h100);
      send_frame(3, 9'h002, 8'h70);
      sw_rd(1, v);
      chk("R4 wrapped to base after release", v, 32'h01000003);
      rd_byte(258, v);
      chk("R1 byte after wrap", v, {24'd0, fb(8'h70, 2)});
      clr_flags(3'b111);

      // new base 0x44 -> 0x40; single self-wrapping descriptor with buffer at 0x300
      sw_wr(16, 32'h302);
      sw_wr(17, 32'h0);
      sw_wr(224, 32'hDEADBEEF);
      load_base(32'h44);
      send_frame(130, 9'h080, 8'h05);
      sw_rd(17, v);
      chk("R6 frame at new base / R7 length capped", v, 32'h40000080);
      chk("R7 overrun flag", {31'd0, overrun_flag}, 32'd1);
      sw_rd(224, v);
      chk("R7 no write past buffer", v, 32'hDEADBEEF);
      rd_byte(32'h300 + 127, v);
      chk("R7 last stored byte", v, {24'd0, fb(8'h05, 127)});
      clr_flags(3'b010);
      chk("R8 selective clear ovr", {30'd0, overrun_flag, rx_done_flag}, 32'd1);
      clr_flags(3'b001);

      // descriptor at 0x40 is owned: stray beats must not start a frame
      @(negedge clk);
      rx_valid = 1; rx_sof = 0; rx_data = 8'hAA;
      @(negedge clk);
      rx_valid = 0; rx_sof = 1; rx_eof = 1;
      @(negedge clk);
      rx_sof = 0; rx_eof = 0;
      @(negedge clk);
      chk("R10 stray beats ignored", {29'd0, no_buf_flag, overrun_flag, rx_done_flag}, 32'd0);

      // release and send again: pointer returned to 0x40 via wrap
      sw_wr(16, 32'h302);
      send_frame(2, 9'h000, 8'hC0);
      sw_rd(17, v);
      chk("R4 wrap returns to new base", v, 32'h00000002);
      sw_rd(16, v);
      chk("R3 owner set keeps wrap", v, 32'h303);
      rd_byte(32'h301, v);
      chk("R1 second byte lane", v, {24'd0, fb(8'hC0, 1)});

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule